// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits in a memory controller and takes a DDR SDRAM from power-on to the point where normal traffic may start. It waits for an input saying that the supplies and the clock are stable. It then holds the clock-enable low for a timed settling period of many cycles. After that it drives the command bus through a fixed chain of commands:

- a NOP while clock-enable goes high;
- a precharge of all banks;
- a write to the extended mode register that enables the DLL;
- a write to the main mode register that resets the DLL and sets the operating fields;
- a DLL lock wait;
- a second precharge of all banks;
- two auto refreshes;
- a last main mode register write with the DLL reset bit cleared.

A parameterized stretch of NOP cycles follows every command. When the last stretch ends, the sequencer raises a done flag and parks the bus in NOP.

The mode register contents are parameters: burst length, burst type, CAS latency and the position of the DLL reset bit. The timing counts are also parameters. The settling period is given in nanoseconds and converted to cycles from the clock period. The precharge, mode-write and refresh recovery gaps and the DLL lock wait are given in cycles. All outputs come straight from flops.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and after reset until the stable indication is first sampled high, the bus carries CKE low and NOP (CS#,RAS#,CAS#,WE# = 0,1,1,1) with BA = 0, A = 0 and done low. Every NOP the block drives has BA = 0 and A = 0.
- R2: The first clock edge that samples the stable indication high starts the settling period. For the next PU cycles, where PU = ceil(POWERUP_NS*1000 / CLK_PERIOD_PS), the bus shows CKE low with NOP.
- R3: The cycle after the settling period shows CKE high with NOP. CKE then stays high until reset.
- R4: Next comes precharge-all: CS#,RAS#,CAS#,WE# = 0,0,1,0, with A10 high and all other A bits and BA at 0. It is followed by T_RP NOP cycles.
- R5: Next comes an extended mode register write: CS#,RAS#,CAS#,WE# = 0,0,0,0, BA = 01, A = EMR_VAL. It is followed by T_MRD NOP cycles.
- R6: Next comes a main mode register write with BA = 00 and A = MR_VAL with bit DLL_RST_BIT set. It is followed by max(T_DLL, T_MRD) NOP cycles.
- R7: Next comes a second precharge-all, encoded as in R4, followed by T_RP NOPs. Then come exactly two auto refreshes (0,0,0,1, BA = 0, A = 0), each followed by T_RFC NOPs. No further refresh is issued.
- R8: Next comes a main mode register write with BA = 00 and A = MR_VAL with bit DLL_RST_BIT cleared. After its T_MRD NOPs, done goes high and stays high, with CKE high and NOP, until reset.
- R9: Once the sequence has started, the stable indication is ignored. Dropping it changes no later bus cycle.
- R10: Reset at any point returns the bus to the R1 state. The next sampled stable indication restarts the sequence from R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable_i | input | 1 | Supplies and clock reported stable |
| cke_o | output | 1 | Clock enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address, selects the mode register target |
| addr_o | output | ADDR_W | Address bus: mode register value or A10 precharge-all |
| init_done_o | output | 1 | High once normal operation may begin |

## Verification
The bus registers are loaded from the next state, so every command appears exactly one clock after the edge that decides it. The first settling cycle is visible one cycle after the edge that samples the stable indication, and every later bus cycle follows back to back. The bench therefore builds the whole expected schedule as a per-cycle queue from the requirement formulas. It pops one entry at each falling edge, starting with the falling edge after the stable indication is raised, and compares the full bus every cycle. The counts it checks are the settling length, the gaps, the DLL wait and the point where done rises. Reset is asynchronous, so its effect is checked at the first falling edge after reset is asserted.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PU_WAIT,
        ST_CKE_NOP,
        ST_PRE_A,
        ST_EMRS,
        ST_MRS_DLL,
        ST_PRE_B,
        ST_REF_A,
        ST_REF_B,
        ST_MRS_OP,
        ST_GAP,
        ST_READY
    } init_state_e;

    typedef struct packed {
        init_state_e state;
        init_state_e after;
    } seq_t;

    // Command codes in the order {CS#, RAS#, CAS#, WE#}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_PRE = 4'b0010;
    localparam logic [3:0] CMD_REF = 4'b0001;
    localparam logic [3:0] CMD_MRS = 4'b0000;

    localparam int PALL_BIT = 10;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = value_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int               ADDR_W      = 13,
    parameter int               BA_W        = 2,
    parameter logic [ADDR_W-1:0] MR_VAL     = 13'h022,
    parameter logic [ADDR_W-1:0] EMR_VAL    = 13'h000,
    parameter int               DLL_RST_BIT = 8
) (
    input  init_state_e       state_i,
    output logic              cke_o,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o
);

    localparam logic [ADDR_W-1:0] DLL_MASK  = ADDR_W'(1) << DLL_RST_BIT;
    localparam logic [ADDR_W-1:0] PALL_MASK = ADDR_W'(1) << PALL_BIT;

    always_comb begin
        cke_o   = 1'b1;
        cmd_o   = CMD_NOP;
        ba_o    = '0;
        addr_o  = '0;
        ready_o = 1'b0;
        unique case (state_i)
            ST_IDLE, ST_PU_WAIT: begin
                cke_o = 1'b0;
            end
            ST_CKE_NOP, ST_GAP: begin
                cmd_o = CMD_NOP;
            end
            ST_PRE_A, ST_PRE_B: begin
                cmd_o  = CMD_PRE;
                addr_o = PALL_MASK;
            end
            ST_EMRS: begin
                cmd_o  = CMD_MRS;
                ba_o   = BA_W'(1);
                addr_o = EMR_VAL;
            end
            ST_MRS_DLL: begin
                cmd_o  = CMD_MRS;
                addr_o = MR_VAL | DLL_MASK;
            end
            ST_REF_A, ST_REF_B: begin
                cmd_o = CMD_REF;
            end
            ST_MRS_OP: begin
                cmd_o  = CMD_MRS;
                addr_o = MR_VAL & ~DLL_MASK;
            end
            ST_READY: begin
                ready_o = 1'b1;
            end
            default: begin
                cke_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int                ADDR_W        = 13,
    parameter int                BA_W          = 2,
    parameter int                CLK_PERIOD_PS = 5000,
    parameter int                POWERUP_NS    = 200000,
    parameter int                T_RP          = 3,
    parameter int                T_MRD         = 2,
    parameter int                T_RFC         = 14,
    parameter int                T_DLL         = 200,
    parameter logic [ADDR_W-1:0] MR_VAL        = 13'h022,
    parameter logic [ADDR_W-1:0] EMR_VAL       = 13'h000,
    parameter int                DLL_RST_BIT   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_stable_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              init_done_o
);

    // Settling period rounded up to whole cycles
    localparam int PU_CYC  = (POWERUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int DLL_GAP = (T_DLL > T_MRD) ? T_DLL : T_MRD;
    localparam int MAX_A   = (PU_CYC > DLL_GAP) ? PU_CYC : DLL_GAP;
    localparam int MAX_B   = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_W + 1);

    localparam logic [CNT_W-1:0] LD_PU  = CNT_W'(PU_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_DLL = CNT_W'(DLL_GAP - 1);

    typedef struct packed {
        logic              cke;
        logic [3:0]        cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              rdy;
    } bus_t;

    localparam bus_t BUS_RST = '{cke: 1'b0, cmd: CMD_NOP, ba: '0, addr: '0, rdy: 1'b0};

    seq_t             seq_d, seq_q;
    bus_t             bus_d, bus_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    ddr_init_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_done)
    );

    // Bus for the cycle after this edge, decoded from the next state
    ddr_init_cmd_enc #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .MR_VAL      (MR_VAL),
        .EMR_VAL     (EMR_VAL),
        .DLL_RST_BIT (DLL_RST_BIT)
    ) enc_i (
        .state_i (seq_d.state),
        .cke_o   (bus_d.cke),
        .cmd_o   (bus_d.cmd),
        .ba_o    (bus_d.ba),
        .addr_o  (bus_d.addr),
        .ready_o (bus_d.rdy)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (pwr_stable_i) begin
                    seq_d.state = ST_PU_WAIT;
                    tmr_load    = 1'b1;
                    tmr_val     = LD_PU;
                end
            end
            ST_PU_WAIT: begin
                if (tmr_done) begin
                    seq_d.state = ST_CKE_NOP;
                end
            end
            ST_CKE_NOP: begin
                seq_d.state = ST_PRE_A;
            end
            ST_PRE_A: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_EMRS;
                tmr_load    = 1'b1;
                tmr_val     = LD_RP;
            end
            ST_EMRS: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_MRS_DLL;
                tmr_load    = 1'b1;
                tmr_val     = LD_MRD;
            end
            ST_MRS_DLL: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_PRE_B;
                tmr_load    = 1'b1;
                tmr_val     = LD_DLL;
            end
            ST_PRE_B: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_REF_A;
                tmr_load    = 1'b1;
                tmr_val     = LD_RP;
            end
            ST_REF_A: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_REF_B;
                tmr_load    = 1'b1;
                tmr_val     = LD_RFC;
            end
            ST_REF_B: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_MRS_OP;
                tmr_load    = 1'b1;
                tmr_val     = LD_RFC;
            end
            ST_MRS_OP: begin
                seq_d.state = ST_GAP;
                seq_d.after = ST_READY;
                tmr_load    = 1'b1;
                tmr_val     = LD_MRD;
            end
            ST_GAP: begin
                if (tmr_done) begin
                    seq_d.state = seq_q.after;
                end
            end
            ST_READY: begin
                seq_d.state = ST_READY;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ST_IDLE, after: ST_IDLE};
            bus_q <= BUS_RST;
        end else begin
            seq_q <= seq_d;
            bus_q <= bus_d;
        end
    end

    assign cke_o       = bus_q.cke;
    assign cs_n_o      = bus_q.cmd[3];
    assign ras_n_o     = bus_q.cmd[2];
    assign cas_n_o     = bus_q.cmd[1];
    assign we_n_o      = bus_q.cmd[0];
    assign ba_o        = bus_q.ba;
    assign addr_o      = bus_q.addr;
    assign init_done_o = bus_q.rdy;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
    parameter int                ADDR_W      = 13,
    parameter int                BA_W        = 2,
    parameter int                T_DLL       = 200,
    parameter logic [ADDR_W-1:0] MR_VAL      = 13'h022,
    parameter int                DLL_RST_BIT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_o,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [BA_W-1:0]   ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              init_done_o
);

    localparam int                DW       = $clog2(T_DLL + 1);
    localparam logic [ADDR_W-1:0] DLL_ADDR = MR_VAL | (ADDR_W'(1) << DLL_RST_BIT);
    localparam logic [ADDR_W-1:0] PALL     = ADDR_W'(1) << 10;

    logic [3:0] cmd;
    logic       is_nop, is_pre, is_ref, is_dll_wr;
    logic [DW-1:0] dll_cnt_q;
    logic [1:0]    ref_cnt_q;

    assign cmd       = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    assign is_nop    = (cmd == 4'b0111);
    assign is_pre    = (cmd == 4'b0010);
    assign is_ref    = (cmd == 4'b0001);
    assign is_dll_wr = (cmd == 4'b0000) && (ba_o == '0) && (addr_o == DLL_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dll_cnt_q <= '0;
            ref_cnt_q <= '0;
        end else begin
            if (is_dll_wr) begin
                dll_cnt_q <= DW'(T_DLL);
            end else if (dll_cnt_q != '0) begin
                dll_cnt_q <= dll_cnt_q - DW'(1);
            end
            if (is_ref && ref_cnt_q != 2'd3) begin
                ref_cnt_q <= ref_cnt_q + 2'd1;
            end
        end
    end

    // R1
    cke_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> (is_nop && !init_done_o));

    // R3
    cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o);

    // R4
    pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (addr_o == PALL && ba_o == '0));

    // R4
    gap_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_nop |=> is_nop);

    // R6
    dll_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_cnt_q != '0) |-> is_nop);

    // R7
    ref_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (ref_cnt_q < 2'd2));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

    // R8
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> (cke_o && is_nop && ref_cnt_q == 2'd2));

endmodule

bind ddr_init_seq ddr_init_chk #(
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .T_DLL       (T_DLL),
    .MR_VAL      (MR_VAL),
    .DLL_RST_BIT (DLL_RST_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cke_o       (cke_o),
    .cs_n_o      (cs_n_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o),
    .we_n_o      (we_n_o),
    .ba_o        (ba_o),
    .addr_o      (addr_o),
    .init_done_o (init_done_o)
);

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

    localparam int CLK_NS  = 10;
    localparam int CLK_PS  = CLK_NS * 1000;
    localparam int PU_NS   = 3000;
    localparam int TRP     = 3;
    localparam int TMRD    = 2;
    localparam int TRFC    = 7;
    localparam int TDLL    = 200;
    localparam int DLLBIT  = 8;
    localparam logic [12:0] MRV  = 13'h032;
    localparam logic [12:0] EMRV = 13'h002;

    localparam int PU_EXP  = (PU_NS * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int DLL_EXP = (TDLL > TMRD) ? TDLL : TMRD;

    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done_o;
    logic [1:0]  ba;
    logic [12:0] addr;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [20:0] word;
        string       tag;
    } exp_t;

    exp_t sched[$];

    always #(CLK_NS / 2) clk = ~clk;

    ddr_init_seq #(
        .ADDR_W        (13),
        .BA_W          (2),
        .CLK_PERIOD_PS (CLK_PS),
        .POWERUP_NS    (PU_NS),
        .T_RP          (TRP),
        .T_MRD         (TMRD),
        .T_RFC         (TRFC),
        .T_DLL         (TDLL),
        .MR_VAL        (MRV),
        .EMR_VAL       (EMRV),
        .DLL_RST_BIT   (DLLBIT)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_stable_i (pwr),
        .cke_o        (cke),
        .cs_n_o       (cs_n),
        .ras_n_o      (ras_n),
        .cas_n_o      (cas_n),
        .we_n_o       (we_n),
        .ba_o         (ba),
        .addr_o       (addr),
        .init_done_o  (done_o)
    );

    function automatic logic [20:0] pack(input logic k, input logic [3:0] c,
                                         input logic [1:0] b, input logic [12:0] a,
                                         input logic r);
        return {k, c, b, a, r};
    endfunction

    function automatic logic [20:0] actual();
        return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done_o};
    endfunction

    task automatic check(input logic [20:0] exp_w, input string tag);
        checks++;
        if (actual() !== exp_w) begin
            fails++;
            $display("FAIL %s: bus=%h expected %h at %0t", tag, actual(), exp_w, $time);
        end
    endtask

    task automatic add(input logic k, input logic [3:0] c, input logic [1:0] b,
                       input logic [12:0] a, input logic r, input int n, input string t);
        repeat (n) sched.push_back('{word: pack(k, c, b, a, r), tag: t});
    endtask

    task automatic build();
        sched.delete();
        add(0, NOP, 0, 0, 0, PU_EXP, "R2");
        add(1, NOP, 0, 0, 0, 1, "R3");
        add(1, PRE, 0, 13'h0400, 0, 1, "R4");
        add(1, NOP, 0, 0, 0, TRP, "R4");
        add(1, MRS, 2'b01, EMRV, 0, 1, "R5");
        add(1, NOP, 0, 0, 0, TMRD, "R5");
        add(1, MRS, 2'b00, MRV | (13'h1 << DLLBIT), 0, 1, "R6");
        add(1, NOP, 0, 0, 0, DLL_EXP, "R6");
        add(1, PRE, 0, 13'h0400, 0, 1, "R7");
        add(1, NOP, 0, 0, 0, TRP, "R7");
        add(1, REF, 0, 0, 0, 1, "R7");
        add(1, NOP, 0, 0, 0, TRFC, "R7");
        add(1, REF, 0, 0, 0, 1, "R7");
        add(1, NOP, 0, 0, 0, TRFC, "R7");
        add(1, MRS, 2'b00, MRV & ~(13'h1 << DLLBIT), 0, 1, "R8");
        add(1, NOP, 0, 0, 0, TMRD, "R8");
        add(1, NOP, 0, 0, 1, 25, "R8");
    endtask

    // Compare one expected entry per cycle; optionally drop pwr at drop_at,
    // stop after limit entries when limit >= 0
    task automatic run(input int drop_at, input int limit);
        int idx = 0;
        while (sched.size() > 0 && (limit < 0 || idx < limit)) begin
            exp_t e;
            @(negedge clk);
            e = sched.pop_front();
            check(e.word, (drop_at >= 0 && idx > drop_at) ? {e.tag, "/R9"} : e.tag);
            if (idx == drop_at) pwr = 1'b0;
            idx++;
        end
    endtask

    localparam logic [20:0] IDLE_W = {1'b0, 4'b0111, 2'b00, 13'h0000, 1'b0};

    initial begin
        // R1: during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(IDLE_W, "R1");
        end
        rst_n = 1'b1;
        // R1: after reset, indication low
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(IDLE_W, "R1");
        end
        // Full sequence; indication dropped inside the DLL wait (R9)
        pwr = 1'b1;
        build();
        run(PU_EXP + 60, -1);

        // R10: reset from the done state, then restart
        rst_n = 1'b0;
        pwr   = 1'b1;
        @(negedge clk);
        check(IDLE_W, "R10");
        rst_n = 1'b1;
        build();
        run(-1, PU_EXP + 190);
        rst_n = 1'b0;
        @(negedge clk);
        check(IDLE_W, "R10");
        @(negedge clk);
        check(IDLE_W, "R10");
        rst_n = 1'b1;
        build();
        run(-1, -1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule